// File: doc/BRIEF.md
# Multi-Source Event Merger

This block gathers event packets that arrive on twelve independent source inputs and streams them out as one combined event for every trigger. Each source writes into its own word FIFO. When the last word of a packet is accepted, the packet's word count is pushed into a small per-source location queue. Only packets that have a location entry are eligible for readout.

On a trigger, the merger visits the sources in ascending index order. For each source it takes the oldest posted packet and streams its words straight from that source's FIFO to the output handshake port. There is no merge buffer and no staging copy. A source that posts nothing within a programmable number of cycles is skipped and flagged. The event closes with a trailer word that carries the per-source missing flags.

Each source exposes a full flag and a saturating count of dropped writes. Link framing and serialization happen downstream.

Top module: `event_merger`

## Requirements
- R1: After reset, `outValid` is low, every `srcFull` bit is low and every overflow count is zero.
- R2: Within an event, packets appear in ascending source index order. Each packet's words appear contiguously and in the order they were written.
- R3: No word is presented on the output until a trigger has been seen. Posted packets wait in their FIFOs until then.
- R4: Words of a packet whose last word (`srcWrLast` high) has not yet been accepted are never emitted. That packet is read in a later event, once it has been completed.
- R5: A source visited by the merger that still has no posted packet after `timeoutCycles` cycles of waiting is skipped, and its missing flag is set.
- R6: Every event ends with exactly one trailer word, the only word with `outLast` high. Its format is bits 31..24 = 0xE7, bits 23..12 = 0, and bit i of bits 11..0 = 1 if source i was skipped.
- R7: `srcFull[i]` is high while source i holds DEPTH data words or LOC_DEPTH posted packets, and low otherwise.
- R8: A write to a full source is discarded and increments that source's overflow count, which saturates at its all-ones value. No other write changes the count.
- R9: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outLast` hold their values.
- R10: An event takes at most one packet (the oldest) from each source. Further posted packets stay queued for later events.
- R11: Triggers that arrive while an event is in progress are counted, and each one later produces its own event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeoutCycles | input | 16 | Cycles to wait for a source before skipping it |
| trigger | input | 1 | One-cycle pulse requesting one merged event |
| srcWrEn | input | 12 | Per-source word write enable |
| srcWrLast | input | 12 | Marks the written word as the last of its packet |
| srcWrData | input | 384 | Per-source write data, source i at bits 32i+31..32i |
| srcFull | output | 12 | Per-source full flag |
| srcOvfCount | output | 96 | Per-source dropped-write count, source i at bits 8i+7..8i |
| outData | output | 32 | Output word |
| outValid | output | 1 | Output word valid |
| outLast | output | 1 | Output word is the event trailer |
| outReady | input | 1 | Downstream accepts the word |

## Verification
The bench targets the following corner cases, and for each one it names the wrong behaviour it would catch.
- Half-written packets when a trigger arrives. A merger that tracked raw FIFO occupancy instead of posted entries would leak those words into the current event.
- Two or more packets queued on one source. A design that drained the whole FIFO would merge two events into one.
- Sources that never answer. A broken timeout would either hang the event or leave the trailer mask wrong.
- Stalled output handshakes. A read pointer that advanced without a handshake would lose words.
- Writes into full sources, checked through the overflow counts, the full flag and the absence of the dropped word from the stream.

// File: rtl/merger_pkg.sv
package merger_pkg;
  localparam int SEL_W = 8;
  localparam logic [7:0] TRAIL_TAG = 8'hE7;

  typedef struct packed {
    logic [SEL_W-1:0] srcSel;
    logic             popWord;
    logic             popLoc;
  } mrgStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_STREAM, ST_TRAIL} mrgState_t;
endpackage

// File: rtl/merger_src_fifo.sv
module merger_src_fifo #(
  parameter int DW        = 32,
  parameter int DEPTH     = 128,
  parameter int LOC_DEPTH = 4,
  parameter int OVF_W     = 8,
  parameter int LEN_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrLast,
  input  logic [DW-1:0]    wrData,
  output logic             full,
  output logic [OVF_W-1:0] ovfCount,
  input  logic             popWord,
  input  logic             popLoc,
  output logic [DW-1:0]    rdWord,
  output logic             locValid,
  output logic [LEN_W-1:0] locLen
);
  localparam int AW  = $clog2(DEPTH);
  localparam int LAW = $clog2(LOC_DEPTH);

  logic [DW-1:0]    mem    [DEPTH];
  logic [LEN_W-1:0] locMem [LOC_DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      dCnt;
  logic [LAW-1:0]   lWr, lRd;
  logic [LAW:0]     lCnt;
  logic [LEN_W-1:0] curLen;
  logic             accept, pushLoc;

  assign full    = (dCnt == (AW+1)'(DEPTH)) || (lCnt == (LAW+1)'(LOC_DEPTH));
  assign accept  = wrEn && !full;
  assign pushLoc = accept && wrLast;

  assign rdWord   = mem[rdPtr];
  assign locValid = (lCnt != '0);
  assign locLen   = locMem[lRd];

  always_ff @(posedge clk) begin
    if (accept)  mem[wrPtr]  <= wrData;
    if (pushLoc) locMem[lWr] <= curLen + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      dCnt     <= '0;
      lWr      <= '0;
      lRd      <= '0;
      lCnt     <= '0;
      curLen   <= '0;
      ovfCount <= '0;
    end else begin
      if (accept) begin
        wrPtr  <= wrPtr + 1'b1;
        curLen <= wrLast ? '0 : curLen + 1'b1;
      end
      if (popWord) rdPtr <= rdPtr + 1'b1;
      dCnt <= dCnt + (AW+1)'(accept) - (AW+1)'(popWord);
      if (pushLoc) lWr <= lWr + 1'b1;
      if (popLoc)  lRd <= lRd + 1'b1;
      lCnt <= lCnt + (LAW+1)'(pushLoc) - (LAW+1)'(popLoc);
      if (wrEn && full && (ovfCount != '1)) ovfCount <= ovfCount + 1'b1;
    end
  end
endmodule

// File: rtl/merger_datapath.sv
module merger_datapath
  import merger_pkg::*;
#(
  parameter int NUM_SRC   = 12,
  parameter int DW        = 32,
  parameter int DEPTH     = 128,
  parameter int LOC_DEPTH = 4,
  parameter int OVF_W     = 8,
  parameter int LEN_W     = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_SRC-1:0]              wrEn,
  input  logic [NUM_SRC-1:0]              wrLast,
  input  logic [NUM_SRC-1:0][DW-1:0]      wrData,
  output logic [NUM_SRC-1:0]              full,
  output logic [NUM_SRC-1:0][OVF_W-1:0]   ovfCount,
  input  mrgStrobe_t                      strobe,
  output logic [DW-1:0]                   selWord,
  output logic [LEN_W-1:0]                selLen,
  output logic [NUM_SRC-1:0]              locValid
);
  logic [NUM_SRC-1:0][DW-1:0]    rdWord;
  logic [NUM_SRC-1:0][LEN_W-1:0] lenArr;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic hit;
    assign hit = (strobe.srcSel == SEL_W'(g));
    merger_src_fifo #(
      .DW(DW), .DEPTH(DEPTH), .LOC_DEPTH(LOC_DEPTH), .OVF_W(OVF_W), .LEN_W(LEN_W)
    ) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .wrEn     (wrEn[g]),
      .wrLast   (wrLast[g]),
      .wrData   (wrData[g]),
      .full     (full[g]),
      .ovfCount (ovfCount[g]),
      .popWord  (strobe.popWord && hit),
      .popLoc   (strobe.popLoc && hit),
      .rdWord   (rdWord[g]),
      .locValid (locValid[g]),
      .locLen   (lenArr[g])
    );
  end

  always_comb begin
    selWord = '0;
    selLen  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strobe.srcSel == SEL_W'(i)) begin
        selWord = rdWord[i];
        selLen  = lenArr[i];
      end
    end
  end
endmodule

// File: rtl/merger_ctrl.sv
module merger_ctrl
  import merger_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int DW      = 32,
  parameter int LEN_W   = 8,
  parameter int TMO_W   = 16,
  parameter int PEND_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigger,
  input  logic [TMO_W-1:0]   timeoutCycles,
  input  logic [NUM_SRC-1:0] locValid,
  input  logic [LEN_W-1:0]   selLen,
  input  logic [DW-1:0]      selWord,
  output mrgStrobe_t         strobe,
  output logic [DW-1:0]      outData,
  output logic               outValid,
  output logic               outLast,
  input  logic               outReady
);
  localparam int PAD_W = DW - 8 - NUM_SRC;

  mrgState_t          state;
  logic [SEL_W-1:0]   src;
  logic [TMO_W-1:0]   waitCnt;
  logic [LEN_W-1:0]   remain;
  logic [NUM_SRC-1:0] missing;
  logic [PEND_W-1:0]  pendTrig;
  logic handshake, locHere, lastSrc, trigStart, timedOut, doAdvance;

  assign outValid  = (state == ST_STREAM) || (state == ST_TRAIL);
  assign outLast   = (state == ST_TRAIL);
  assign outData   = (state == ST_TRAIL) ? {TRAIL_TAG, {PAD_W{1'b0}}, missing} : selWord;
  assign handshake = outValid && outReady;

  always_comb begin
    locHere = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src == SEL_W'(i)) locHere = locValid[i];
  end

  assign lastSrc        = (src == SEL_W'(NUM_SRC - 1));
  assign trigStart      = (state == ST_IDLE) && (pendTrig != '0);
  assign timedOut       = (state == ST_WAIT) && !locHere && (waitCnt >= timeoutCycles);
  assign strobe.srcSel  = src;
  assign strobe.popWord = (state == ST_STREAM) && handshake;
  assign strobe.popLoc  = strobe.popWord && (remain == LEN_W'(1));
  assign doAdvance      = timedOut || strobe.popLoc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      src      <= '0;
      waitCnt  <= '0;
      remain   <= '0;
      missing  <= '0;
      pendTrig <= '0;
    end else begin
      pendTrig <= pendTrig + PEND_W'(trigger && (pendTrig != '1)) - PEND_W'(trigStart);
      if (doAdvance) begin
        waitCnt <= '0;
        if (timedOut) missing <= missing | (NUM_SRC'(1) << src);
        if (lastSrc) state <= ST_TRAIL;
        else begin
          src   <= src + 1'b1;
          state <= ST_WAIT;
        end
      end else begin
        unique case (state)
          ST_IDLE: if (trigStart) begin
            state   <= ST_WAIT;
            src     <= '0;
            missing <= '0;
            waitCnt <= '0;
          end
          ST_WAIT: if (locHere) begin
            state  <= ST_STREAM;
            remain <= selLen;
          end else waitCnt <= waitCnt + 1'b1;
          ST_STREAM: if (strobe.popWord) remain <= remain - 1'b1;
          ST_TRAIL: if (handshake) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/event_merger.sv
module event_merger
  import merger_pkg::*;
#(
  parameter int NUM_SRC   = 12,
  parameter int DW        = 32,
  parameter int DEPTH     = 128,
  parameter int LOC_DEPTH = 4,
  parameter int OVF_W     = 8,
  parameter int TMO_W     = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [TMO_W-1:0]         timeoutCycles,
  input  logic                     trigger,
  input  logic [NUM_SRC-1:0]       srcWrEn,
  input  logic [NUM_SRC-1:0]       srcWrLast,
  input  logic [NUM_SRC*DW-1:0]    srcWrData,
  output logic [NUM_SRC-1:0]       srcFull,
  output logic [NUM_SRC*OVF_W-1:0] srcOvfCount,
  output logic [DW-1:0]            outData,
  output logic                     outValid,
  output logic                     outLast,
  input  logic                     outReady
);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic [NUM_SRC-1:0][DW-1:0]    wrDataArr;
  logic [NUM_SRC-1:0][OVF_W-1:0] ovfArr;
  logic [NUM_SRC-1:0]            locValid;
  logic [DW-1:0]                 selWord;
  logic [LEN_W-1:0]              selLen;
  mrgStrobe_t                    strobe;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlat
    assign wrDataArr[g]                  = srcWrData[g*DW +: DW];
    assign srcOvfCount[g*OVF_W +: OVF_W] = ovfArr[g];
  end

  merger_datapath #(
    .NUM_SRC(NUM_SRC), .DW(DW), .DEPTH(DEPTH), .LOC_DEPTH(LOC_DEPTH),
    .OVF_W(OVF_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (srcWrEn),
    .wrLast   (srcWrLast),
    .wrData   (wrDataArr),
    .full     (srcFull),
    .ovfCount (ovfArr),
    .strobe   (strobe),
    .selWord  (selWord),
    .selLen   (selLen),
    .locValid (locValid)
  );

  merger_ctrl #(
    .NUM_SRC(NUM_SRC), .DW(DW), .LEN_W(LEN_W), .TMO_W(TMO_W), .PEND_W(4)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .trigger       (trigger),
    .timeoutCycles (timeoutCycles),
    .locValid      (locValid),
    .selLen        (selLen),
    .selWord       (selWord),
    .strobe        (strobe),
    .outData       (outData),
    .outValid      (outValid),
    .outLast       (outLast),
    .outReady      (outReady)
  );
endmodule

// File: rtl/event_merger_chk.sv
module event_merger_chk #(
  parameter int NUM_SRC   = 12,
  parameter int DW        = 32,
  parameter int DEPTH     = 128,
  parameter int LOC_DEPTH = 4,
  parameter int OVF_W     = 8,
  parameter int TMO_W     = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [TMO_W-1:0]         timeoutCycles,
  input logic                     trigger,
  input logic [NUM_SRC-1:0]       srcWrEn,
  input logic [NUM_SRC-1:0]       srcWrLast,
  input logic [NUM_SRC*DW-1:0]    srcWrData,
  input logic [NUM_SRC-1:0]       srcFull,
  input logic [NUM_SRC*OVF_W-1:0] srcOvfCount,
  input logic [DW-1:0]            outData,
  input logic                     outValid,
  input logic                     outLast,
  input logic                     outReady
);
  logic [7:0] trigOwed;

  always_ff @(posedge clk) begin
    if (!rstN) trigOwed <= '0;
    else trigOwed <= trigOwed + 8'(trigger) - 8'(outValid && outReady && outLast);
  end

  AST_NO_OUT_WITHOUT_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (trigOwed != '0)); // R3

  AST_TRAILER_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> (outData[DW-1:DW-8] == 8'hE7)); // R6

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast))); // R9

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrcChk
    AST_OVF_COUNT_UP: assert property (@(posedge clk) disable iff (!rstN)
      (srcWrEn[i] && srcFull[i] && (srcOvfCount[i*OVF_W +: OVF_W] != '1))
      |=> (srcOvfCount[i*OVF_W +: OVF_W] == $past(srcOvfCount[i*OVF_W +: OVF_W]) + 1'b1)); // R8

    AST_OVF_STILL: assert property (@(posedge clk) disable iff (!rstN)
      !(srcWrEn[i] && srcFull[i]) |=> $stable(srcOvfCount[i*OVF_W +: OVF_W])); // R8
  end
endmodule

bind event_merger event_merger_chk #(
  .NUM_SRC(NUM_SRC), .DW(DW), .DEPTH(DEPTH), .LOC_DEPTH(LOC_DEPTH),
  .OVF_W(OVF_W), .TMO_W(TMO_W)
) u_chk (.*);

// File: tb/event_merger_tb.sv
module event_merger_tb;
  localparam int NS = 12, DW = 32, DEPTH = 128, OW = 8;
  localparam logic [16:0] VEC [6] = '{
    {12'hFFF, 5'd1}, {12'h001, 5'd3}, {12'h800, 5'd2},
    {12'hA5A, 5'd6}, {12'h000, 5'd1}, {12'h3C3, 5'd4}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, trigger, outValid, outLast, outReady;
  logic [15:0] timeoutCycles;
  logic [NS-1:0] srcWrEn, srcWrLast, srcFull;
  logic [NS*DW-1:0] srcWrData;
  logic [NS*OW-1:0] srcOvfCount;
  logic [DW-1:0] outData;

  int checks = 0, errors = 0, cyc = 0, expN = 0, gotN = 0;
  bit bpOn = 0;
  logic [31:0] expData [512];
  logic [31:0] gotData [512];

  event_merger u_dut (
    .clk(clk), .rstN(rstN), .timeoutCycles(timeoutCycles), .trigger(trigger),
    .srcWrEn(srcWrEn), .srcWrLast(srcWrLast), .srcWrData(srcWrData),
    .srcFull(srcFull), .srcOvfCount(srcOvfCount), .outData(outData),
    .outValid(outValid), .outLast(outLast), .outReady(outReady)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(int ev, int src, int idx);
    return {4'hD, 4'(ev), 4'(src), 4'h0, 16'(idx)};
  endfunction

  task automatic wrWord(int src, logic [31:0] d, bit last);
    @(negedge clk);
    srcWrEn[src] = 1'b1;
    srcWrLast[src] = last;
    srcWrData[src*DW +: DW] = d;
    @(negedge clk);
    srcWrEn = '0;
    srcWrLast = '0;
  endtask

  task automatic wrPkt(int src, int len, int ev, bit addExp);
    for (int k = 0; k < len; k++) begin
      wrWord(src, mkWord(ev, src, k), k == len - 1);
      if (addExp) begin
        expData[expN] = mkWord(ev, src, k);
        expN++;
      end
    end
  endtask

  task automatic pulseTrig;
    @(negedge clk) trigger = 1'b1;
    @(negedge clk) trigger = 1'b0;
  endtask

  // accepts words until the trailer; R9 hold checked while stalled
  task automatic collect;
    logic [31:0] held;
    bit heldV, done;
    gotN = 0; done = 0; heldV = 0; held = '0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (heldV) chk(outValid && outData == held, "R9 output held under stall", outData, held);
      outReady = bpOn ? (cyc % 3 != 0) : 1'b1;
      heldV = 0;
      if (outValid) begin
        if (outReady) begin
          if (gotN < 512) gotData[gotN] = outData;
          gotN++;
          if (outLast) done = 1;
        end else begin
          held = outData;
          heldV = 1;
        end
      end
    end
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic cmpEvent(string tag, logic [11:0] miss);
    int bad;
    bad = -1;
    expData[expN] = {8'hE7, 12'h0, miss};
    expN++;
    chk(gotN == expN, {"R2 word count ", tag}, gotN, expN);
    for (int k = 0; k < expN && k < gotN; k++)
      if (bad < 0 && gotData[k] !== expData[k]) bad = k;
    chk(bad < 0, {"R2 source order and word order ", tag},
        bad >= 0 ? gotData[bad] : '0, bad >= 0 ? expData[bad] : '0);
    chk(gotN > 0 && gotN <= 512 && gotData[gotN-1] == expData[expN-1],
        {"R5 R6 trailer mask ", tag}, gotN > 0 ? gotData[gotN-1] : '0, expData[expN-1]);
  endtask

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    bit quiet;
    rstN = 1'b0; trigger = 1'b0; outReady = 1'b0; timeoutCycles = 16'd20;
    srcWrEn = '0; srcWrLast = '0; srcWrData = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!outValid, "R1 outValid after reset", 32'(outValid), 32'h0);
    chk(srcFull == '0, "R1 srcFull after reset", 32'(srcFull), 32'h0);
    chk(srcOvfCount == '0, "R1 overflow counts after reset", srcOvfCount[31:0], 32'h0);
    rstN = 1'b1;

    // R3 posted data waits for a trigger
    expN = 0;
    wrPkt(0, 5, 1, 1);
    quiet = 1;
    repeat (40) begin
      @(negedge clk);
      if (outValid) quiet = 0;
    end
    chk(quiet, "R3 no output before trigger", 32'(!quiet), 32'h0);
    pulseTrig();
    collect();
    cmpEvent("R3 event", 12'hFFE);

    // table of source patterns and lengths
    for (int v = 0; v < 6; v++) begin
      expN = 0;
      bpOn = (v % 2) == 1;
      for (int s = 0; s < NS; s++)
        if (VEC[v][5+s]) wrPkt(s, int'(VEC[v][4:0]) + s, v + 2, 1);
      pulseTrig();
      collect();
      cmpEvent($sformatf("table %0d", v), ~VEC[v][16:5]);
    end
    bpOn = 0;

    // R4 unfinished packet is skipped, then read once complete
    expN = 0;
    for (int k = 0; k < 3; k++) wrWord(1, mkWord(9, 1, k), 1'b0);
    pulseTrig();
    collect();
    cmpEvent("R4 unposted", 12'hFFF);
    expN = 0;
    for (int k = 0; k < 4; k++) begin
      expData[expN] = mkWord(9, 1, k);
      expN++;
    end
    wrWord(1, mkWord(9, 1, 3), 1'b1);
    pulseTrig();
    collect();
    cmpEvent("R4 completed", 12'hFFD);

    // R7 location queue full, R8 drop, R10 one packet per event, R11 queued triggers
    for (int p = 0; p < 4; p++) wrPkt(4, 2, 10 + p, 0);
    chk(srcFull[4], "R7 full on posted-packet limit", 32'(srcFull[4]), 32'h1);
    wrWord(4, 32'hBAD0BAD0, 1'b1);
    chk(srcOvfCount[4*OW +: OW] == 8'd1, "R8 dropped write counted",
        32'(srcOvfCount[4*OW +: OW]), 32'h1);
    for (int p = 0; p < 4; p++) pulseTrig();
    for (int p = 0; p < 4; p++) begin
      expN = 0;
      for (int k = 0; k < 2; k++) begin
        expData[expN] = mkWord(10 + p, 4, k);
        expN++;
      end
      bpOn = (p == 2);
      collect();
      cmpEvent($sformatf("R10 R11 queued event %0d", p), 12'hFEF);
    end
    bpOn = 0;
    chk(!srcFull[4], "R7 full clears after drain", 32'(srcFull[4]), 32'h0);

    // R7 data full, R8 saturation
    for (int k = 0; k < DEPTH; k++) wrWord(5, mkWord(0, 5, k), 1'b0);
    chk(srcFull[5], "R7 full on data limit", 32'(srcFull[5]), 32'h1);
    chk(srcOvfCount[5*OW +: OW] == 8'd0, "R8 no count before full",
        32'(srcOvfCount[5*OW +: OW]), 32'h0);
    for (int k = 0; k < 260; k++) wrWord(5, 32'h0, 1'b0);
    chk(srcOvfCount[5*OW +: OW] == 8'hFF, "R8 count saturates",
        32'(srcOvfCount[5*OW +: OW]), 32'hFF);
    chk(srcOvfCount[4*OW +: OW] == 8'd1, "R8 other source untouched",
        32'(srcOvfCount[4*OW +: OW]), 32'h1);

    finishRun();
  end
endmodule